// File: doc/BRIEF.md
# Issue-Stage Flow and Stall Controller

This block governs the flow of instruction groups into a back-end issue stage of a superscalar core. It tracks whether the stage is idle, running, blocked, draining or recovering from a squash. It sends a stall signal back to the stage that supplies groups, and it reports how many instruction-queue slots are free. When the stage is blocked, groups that are already in flight are caught in a small skid buffer. When the blocking condition clears, those groups are replayed one per cycle.

Groups arrive with a valid bit and no ready. Back-pressure works through `up_stall_o`. The supplier must stop sending new groups once it sees the stall. Groups that were already launched and arrive while blocked are still captured. The skid buffer holds them in arrival order. The replay port is also valid-only: the stage accepts a replayed group on every cycle in which `replay_valid_o` is high and no commit stall or squash is present. Commit-side stall and squash indications override the normal flow. A squash discards everything held in the buffer.

Top module: `iss_stage_flow_ctrl`

## Requirements
- R1: After reset, `up_stall_o`, `run_en_o`, `replay_valid_o` and `up_free_o` are all 0, the block is idle and the skid buffer is empty.
- R2: While idle, the block stays idle (`run_en_o`=0) until a cycle with `grp_valid_i`=1. It is running (`run_en_o`=1, `up_stall_o`=0) from the next cycle.
- R3: In the running state, `cmt_stall_i`=1 moves the block to blocked, and the group present that cycle (if valid) is saved. Commit stall takes priority over squash in that state. Blocked shows as `up_stall_o`=1, `run_en_o`=0.
- R4: In the blocked state, `up_stall_o` stays 1 every cycle, and every valid group that arrives is appended to the skid buffer.
- R5: The blocked state is left for draining only in a cycle where `cmt_stall_i`=0 and `iq_full_i`=0. Otherwise the block stays blocked.
- R6: While draining, `run_en_o`=1 and `up_stall_o`=1. The buffered groups appear on `replay_valid_o`/`replay_data_o` in arrival order, one per cycle. After the last one is taken, the block is running again with `up_stall_o`=0. If the buffer is empty on entry, the block runs again after one cycle.
- R7: In the running state, a valid group that arrives while `iq_full_i`=1 and `cmt_stall_i`=0 and no squash is present moves the block to blocked, and that group is saved.
- R8: `cmt_squash_i`=1 or `rob_squashing_i`=1 moves the block from running, blocked or draining to squashing (`run_en_o`=0, `up_stall_o`=0). The block leaves squashing for running only in a cycle where both inputs are 0.
- R9: `up_free_o` equals the value of `iq_free_i` from the previous cycle, in every state.
- R10: Entering squashing empties the skid buffer. Groups that arrive while squashing are dropped and are never replayed.
- R11: The skid buffer holds up to `SKID_DEPTH` (default 4) groups, and a full buffer replays all of them in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid_i | input | 1 | Incoming instruction group is present |
| grp_data_i | input | GRP_W | Incoming instruction group payload |
| cmt_stall_i | input | 1 | Stall request from the commit stage |
| cmt_squash_i | input | 1 | Squash request from the commit stage |
| rob_squashing_i | input | 1 | Reorder buffer is still squashing |
| iq_full_i | input | 1 | Instruction queue has no free slot |
| iq_free_i | input | FREE_W | Count of free instruction-queue slots |
| up_stall_o | output | 1 | Stall toward the group supplier |
| run_en_o | output | 1 | Stage may process groups this cycle |
| replay_valid_o | output | 1 | A buffered group is offered for replay |
| replay_data_o | output | GRP_W | Payload of the oldest buffered group |
| up_free_o | output | FREE_W | Registered free-slot count for the supplier |

## Verification
The assertions assume that the supplier respects the stall signal closely enough that the skid buffer never has to take a group while it is full. They also assume that the squash inputs eventually clear. The stimulus launches at most four groups into any blocked period. Every squash request is held for only a few cycles before both squash sources drop together, so each squash episode ends.

// File: rtl/iss_flow_pkg.sv
package iss_flow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_SQUASH = 3'd4
  } flow_state_t;

endpackage

// File: rtl/iss_flow_skid.sv
module iss_flow_skid #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [W-1:0]     head_data,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [W-1:0]     slots_q [DEPTH];
  logic [IDX_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) slots_q[wr_q] <= push_data;
  end

  assign head_data = slots_q[rd_q];
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/iss_flow_fsm.sv
module iss_flow_fsm
  import iss_flow_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_valid,
  input  logic             cmt_stall,
  input  logic             cmt_squash,
  input  logic             rob_squashing,
  input  logic             iq_full,
  input  logic [CNT_W-1:0] skid_count,
  input  logic             skid_empty,
  output flow_state_t      state,
  output logic             skid_push,
  output logic             skid_pop,
  output logic             skid_flush
);

  flow_state_t st_q, st_d;
  logic        any_squash;

  assign any_squash = cmt_squash | rob_squashing;

  always_comb begin
    st_d       = st_q;
    skid_push  = 1'b0;
    skid_pop   = 1'b0;
    skid_flush = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (grp_valid) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (cmt_stall) begin
          st_d      = ST_BLOCK;
          skid_push = grp_valid;
        end else if (any_squash) begin
          st_d       = ST_SQUASH;
          skid_flush = 1'b1;
        end else if (iq_full && grp_valid) begin
          st_d      = ST_BLOCK;
          skid_push = 1'b1;
        end
      end
      ST_BLOCK: begin
        if (any_squash) begin
          st_d       = ST_SQUASH;
          skid_flush = 1'b1;
        end else begin
          skid_push = grp_valid;
          if (!cmt_stall && !iq_full) st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (any_squash) begin
          st_d       = ST_SQUASH;
          skid_flush = 1'b1;
        end else if (cmt_stall) begin
          st_d      = ST_BLOCK;
          skid_push = grp_valid;
        end else begin
          skid_push = grp_valid;
          skid_pop  = !skid_empty;
          if (!grp_valid && (skid_count <= CNT_W'(1))) st_d = ST_RUN;
        end
      end
      ST_SQUASH: begin
        if (!any_squash) st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/iss_flow_free.sv
module iss_flow_free #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] free_in,
  output logic [W-1:0] free_out
);

  logic [W-1:0] free_q;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '0;
    else        free_q <= free_in;
  end

  assign free_out = free_q;

endmodule

// File: rtl/iss_stage_flow_ctrl.sv
module iss_stage_flow_ctrl
  import iss_flow_pkg::*;
#(
  parameter int GRP_W      = 32,
  parameter int SKID_DEPTH = 4,
  parameter int FREE_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_valid_i,
  input  logic [GRP_W-1:0]  grp_data_i,
  input  logic              cmt_stall_i,
  input  logic              cmt_squash_i,
  input  logic              rob_squashing_i,
  input  logic              iq_full_i,
  input  logic [FREE_W-1:0] iq_free_i,
  output logic              up_stall_o,
  output logic              run_en_o,
  output logic              replay_valid_o,
  output logic [GRP_W-1:0]  replay_data_o,
  output logic [FREE_W-1:0] up_free_o
);

  localparam int CNT_W = $clog2(SKID_DEPTH + 1);

  flow_state_t      state;
  logic             skid_push, skid_pop, skid_flush;
  logic [CNT_W-1:0] skid_count;
  logic             skid_empty, skid_full;

  iss_flow_fsm #(.DEPTH(SKID_DEPTH)) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .grp_valid     (grp_valid_i),
    .cmt_stall     (cmt_stall_i),
    .cmt_squash    (cmt_squash_i),
    .rob_squashing (rob_squashing_i),
    .iq_full       (iq_full_i),
    .skid_count    (skid_count),
    .skid_empty    (skid_empty),
    .state         (state),
    .skid_push     (skid_push),
    .skid_pop      (skid_pop),
    .skid_flush    (skid_flush)
  );

  iss_flow_skid #(.W(GRP_W), .DEPTH(SKID_DEPTH)) skid_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (skid_push),
    .push_data (grp_data_i),
    .pop       (skid_pop),
    .flush     (skid_flush),
    .head_data (replay_data_o),
    .count     (skid_count),
    .empty     (skid_empty),
    .full      (skid_full)
  );

  iss_flow_free #(.W(FREE_W)) free_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .free_in  (iq_free_i),
    .free_out (up_free_o)
  );

  assign up_stall_o     = (state == ST_BLOCK) || (state == ST_DRAIN);
  assign run_en_o       = (state == ST_RUN) || (state == ST_DRAIN);
  assign replay_valid_o = (state == ST_DRAIN) && !skid_empty;

endmodule

// File: rtl/iss_flow_ctrl_chk.sv
module iss_flow_ctrl_chk
  import iss_flow_pkg::*;
#(
  parameter int FREE_W = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmt_stall_i,
  input logic              cmt_squash_i,
  input logic              rob_squashing_i,
  input logic              grp_valid_i,
  input logic [FREE_W-1:0] iq_free_i,
  input logic              up_stall_o,
  input logic              run_en_o,
  input logic [FREE_W-1:0] up_free_o,
  input flow_state_t       state,
  input logic              skid_push,
  input logic              skid_pop,
  input logic              skid_full,
  input logic [CNT_W-1:0]  skid_count
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    skid_push && skid_full |-> skid_pop); // R11

  AST_STALL_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) && cmt_stall_i |=> up_stall_o && !run_en_o); // R3

  AST_BLOCK_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLOCK) && cmt_stall_i && !cmt_squash_i && !rob_squashing_i |=> up_stall_o); // R4

  AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH) && (cmt_squash_i || rob_squashing_i) |=> !run_en_o && !up_stall_o); // R8

  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) && !cmt_stall_i && !cmt_squash_i && !rob_squashing_i
    && !grp_valid_i && (skid_count <= CNT_W'(1)) |=> !up_stall_o && run_en_o); // R6

  AST_FREE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> up_free_o == $past(iq_free_i)); // R9

endmodule

bind iss_stage_flow_ctrl iss_flow_ctrl_chk #(
  .FREE_W(FREE_W),
  .CNT_W ($clog2(SKID_DEPTH + 1))
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmt_stall_i     (cmt_stall_i),
  .cmt_squash_i    (cmt_squash_i),
  .rob_squashing_i (rob_squashing_i),
  .grp_valid_i     (grp_valid_i),
  .iq_free_i       (iq_free_i),
  .up_stall_o      (up_stall_o),
  .run_en_o        (run_en_o),
  .up_free_o       (up_free_o),
  .state           (state),
  .skid_push       (skid_push),
  .skid_pop        (skid_pop),
  .skid_full       (skid_full),
  .skid_count      (skid_count)
);

// File: tb/iss_stage_flow_ctrl_tb_top.sv
module iss_stage_flow_ctrl_tb_top;

  localparam int GW = 32;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grp_valid_i = 1'b0;
  logic [GW-1:0] grp_data_i = '0;
  logic          cmt_stall_i = 1'b0;
  logic          cmt_squash_i = 1'b0;
  logic          rob_squashing_i = 1'b0;
  logic          iq_full_i = 1'b0;
  logic [FW-1:0] iq_free_i = '0;
  logic          up_stall_o, run_en_o, replay_valid_o;
  logic [GW-1:0] replay_data_o;
  logic [FW-1:0] up_free_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [GW-1:0] exp_q[$];

  always #2 clk = ~clk;

  iss_stage_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .grp_valid_i(grp_valid_i), .grp_data_i(grp_data_i),
    .cmt_stall_i(cmt_stall_i), .cmt_squash_i(cmt_squash_i),
    .rob_squashing_i(rob_squashing_i), .iq_full_i(iq_full_i), .iq_free_i(iq_free_i),
    .up_stall_o(up_stall_o), .run_en_o(run_en_o), .replay_valid_o(replay_valid_o),
    .replay_data_o(replay_data_o), .up_free_o(up_free_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input bit st, input bit run);
    chk(up_stall_o == st, {req, " stall"}, up_stall_o, st);
    chk(run_en_o == run, {req, " run_en"}, run_en_o, run);
  endtask

  // driver: apply one cycle of inputs; record groups expected to be replayed
  task automatic tick(input bit v, input logic [GW-1:0] d, input bit stl,
                      input bit sq, input bit rob, input bit full,
                      input bit expect_saved);
    grp_valid_i = v; grp_data_i = d; cmt_stall_i = stl;
    cmt_squash_i = sq; rob_squashing_i = rob; iq_full_i = full;
    if (expect_saved) exp_q.push_back(d);
    @(posedge clk);
    #1;
  endtask

  task automatic idle_tick();
    tick(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: a replayed group is taken when offered with no stall or squash
  always @(negedge clk) begin
    if (rst_n && replay_valid_o && !cmt_stall_i && !cmt_squash_i && !rob_squashing_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected replay", replay_data_o, 0);
      end else begin
        logic [GW-1:0] e;
        e = exp_q.pop_front();
        chk(replay_data_o == e, "R6 replay order", replay_data_o, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_ctl("R1", 1'b0, 1'b0);
    chk(replay_valid_o == 1'b0, "R1 replay_valid", replay_valid_o, 0);
    chk(up_free_o == '0, "R1 free", up_free_o, 0);

    // R2 idle holds without a group, then runs
    tick(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_tick();
    chk_ctl("R2 idle", 1'b0, 1'b0);
    iq_free_i = 6'd13;
    tick(1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_ctl("R2 run", 1'b0, 1'b1);
    chk(up_free_o == 6'd13, "R9 running", up_free_o, 13);

    // R3 commit stall while running saves group A
    tick(1'b1, 32'hA, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk_ctl("R3", 1'b1, 1'b0);
    // R4 more groups while blocked
    tick(1'b1, 32'hB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_ctl("R4 b", 1'b1, 1'b0);
    iq_free_i = 6'd7;
    tick(1'b1, 32'hC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_ctl("R4 c", 1'b1, 1'b0);
    chk(up_free_o == 6'd7, "R9 blocked", up_free_o, 7);
    // R5 queue full keeps it blocked
    tick(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_ctl("R5", 1'b1, 1'b0);
    idle_tick();
    chk_ctl("R6 drain", 1'b1, 1'b1);
    chk(replay_valid_o == 1'b1, "R6 offered", replay_valid_o, 1);
    idle_tick();
    chk_ctl("R6 after A", 1'b1, 1'b1);
    idle_tick();
    chk_ctl("R6 after B", 1'b1, 1'b1);
    idle_tick();
    chk_ctl("R6 after C", 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R6 all replayed", exp_q.size(), 0);

    // R7 queue full with a valid group while running
    tick(1'b1, 32'hD, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk_ctl("R7", 1'b1, 1'b0);
    idle_tick();
    idle_tick();
    chk_ctl("R7 back to run", 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R7 replayed", exp_q.size(), 0);

    // R8 squash from running, held by the reorder-buffer flag
    tick(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_ctl("R8 enter", 1'b0, 1'b0);
    tick(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_ctl("R8 hold", 1'b0, 1'b0);
    iq_free_i = 6'd2;
    idle_tick();
    chk_ctl("R8 exit", 1'b0, 1'b1);
    chk(up_free_o == 6'd2, "R9 squash exit", up_free_o, 2);

    // R10 squash while blocked discards E; F arriving during squash is dropped
    tick(1'b1, 32'hE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_ctl("R8 from blocked", 1'b0, 1'b0);
    tick(1'b1, 32'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle_tick();
    chk_ctl("R10 run", 1'b0, 1'b1);
    tick(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_tick();
    chk(replay_valid_o == 1'b0, "R10 nothing kept", replay_valid_o, 0);
    chk_ctl("R10 drain empty", 1'b1, 1'b1);
    idle_tick();
    chk_ctl("R6 empty drain exit", 1'b0, 1'b1);

    // R11 fill all four slots, replay all
    tick(1'b1, 32'h60, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 1; i < 4; i++) tick(1'b1, 32'h60 + i, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    idle_tick();
    for (int i = 0; i < 3; i++) begin
      idle_tick();
      chk_ctl("R11 draining", 1'b1, 1'b1);
    end
    idle_tick();
    chk_ctl("R11 done", 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R11 all four replayed", exp_q.size(), 0);

    // R8 squash while draining
    tick(1'b1, 32'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle_tick();
    tick(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_ctl("R8 from drain", 1'b0, 1'b0);
    idle_tick();
    idle_tick();
    chk(replay_valid_o == 1'b0, "R10 drain flushed", replay_valid_o, 0);
    chk(exp_q.size() == 0, "R10 no leftover", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule